// File: doc/BRIEF.md
# Parallel Port Byte Capture and Reverse Drive

This block sits on the peripheral side of a bidirectional byte-wide parallel port. With the direction bit clear it runs in forward mode. It takes four asynchronous host control lines, synchronizes them and cleans them with a stability filter that can be switched off. On each high-to-low edge of the cleaned strobe it captures the byte on the data pins. It then marks the byte as data or command from the level of the host-acknowledge line at that moment and records this in a two-bit pending field.

With the direction bit set it runs in reverse mode. It drives the data pins from one of two write registers, a data register and a command register. The register written last selects the byte on the pins, and BUSY reports which kind of byte it is. A small register interface gives access to the control bits, the filter sample period, the two byte registers, the pending field and the cleaned host levels. Reads have a latency of one cycle.

Top module: `ecp_port_capture`

## Requirements
- R1: After synchronous reset, the data register (address 0x60) and the command register (0x61) read 00h, pending (0x64) reads 00h, and control (0x62) reads 40h (bit 7 direction = 0, bit 6 filter enable = 1). Sample period (0x63) reads DIV_RST = 3, and pd_oe_o and busy_o are 0.
- R2: In forward mode, a high-to-low edge of the cleaned strobe captures the synchronized data pins. A read of either 0x60 or 0x61 then returns the captured byte.
- R3: Each forward capture sets pending bits [1:0] to 2'b10 when host-ack is low (command byte) and to 2'b01 when it is high (data byte). A read of 0x64 returns the flags and clears them.
- R4: With the filter enabled, a host level is accepted only after three consecutive sample ticks have seen it. With a period of one clock, a 2-cycle strobe pulse is ignored and a 3-cycle pulse is captured.
- R5: With the filter disabled, the synchronized inputs pass through on every clock, so a 1-cycle strobe pulse is captured.
- R6: Sample ticks occur every (value at 0x63) + 1 clocks. At the reset period of 4 clocks, a 6-cycle strobe pulse is not accepted.
- R7: With the direction bit set, pd_oe_o is 1 and pd_o carries the byte of the register written last. In that mode, 0x60 and 0x61 read back their written values.
- R8: In reverse mode, busy_o is 0 when the command register was written last and 1 when the data register was written last. In forward mode busy_o is 0.
- R9: In reverse mode, strobe edges capture nothing: the pending flags stay clear and the captured byte is unchanged.
- R10: Address 0x65 returns the cleaned host levels in bits [3:0] as {init, ack, strobe, select}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel_n_i | input | 1 | Host select-in, asynchronous, active low |
| host_stb_n_i | input | 1 | Host strobe, asynchronous, active low |
| host_ack_n_i | input | 1 | Host acknowledge / auto-feed, asynchronous, low marks command |
| host_init_n_i | input | 1 | Host init, asynchronous, active low |
| pd_i | input | 8 | Data pins, input side |
| pd_o | output | 8 | Data pins, output side |
| pd_oe_o | output | 1 | Data pin output enable |
| busy_o | output | 1 | Byte type in reverse mode (1 data, 0 command) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after reg_rd_i |

## Verification
Suppose the filter history or the sample divider is wrong. Then a pulse that should be rejected shows up as a nonzero pending read a few ticks after the pulse ends, or a valid pulse shows up as a missing capture. Errors in the strobe edge detector or the ack classification appear at the next read of 0x64 as the wrong flag pattern or as flags that do not clear. A wrong last-written selector shows up on pd_o and busy_o two clocks after the register write.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam logic [7:0] A_DATA = 8'h60;
  localparam logic [7:0] A_CMD  = 8'h61;
  localparam logic [7:0] A_CTRL = 8'h62;
  localparam logic [7:0] A_DIV  = 8'h63;
  localparam logic [7:0] A_PEND = 8'h64;
  localparam logic [7:0] A_LVL  = 8'h65;
  localparam int CTRL_DIR = 7;
  localparam int CTRL_FEN = 6;
  localparam int N_CTL = 4;
  // control line index order in the level vector
  localparam int L_SEL  = 0;
  localparam int L_STB  = 1;
  localparam int L_ACK  = 2;
  localparam int L_INIT = 3;
  localparam logic [1:0] PEND_CMD  = 2'b10;
  localparam logic [1:0] PEND_DATA = 2'b01;
endpackage

// File: rtl/ppc_tick_div.sv
module ppc_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= div_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick_o && div_i != '0) ##1 (div_i != '0) |-> !tick_o); // R6
endmodule

// File: rtl/ppc_input_filter.sv
module ppc_input_filter #(
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic tick_i,
  input  logic async_i,
  output logic lvl_o
);
  logic s1_q, s2_q;
  logic [1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= RST_LVL;
      s2_q <= RST_LVL;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= {2{RST_LVL}};
      lvl_o  <= RST_LVL;
    end else if (!en_i) begin
      hist_q <= {2{s2_q}};
      lvl_o  <= s2_q;
    end else if (tick_i) begin
      hist_q <= {hist_q[0], s2_q};
      if (hist_q[1] == s2_q && hist_q[0] == s2_q)
        lvl_o <= s2_q;
    end
  end

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(en_i && !tick_i) |-> $stable(lvl_o)); // R4
endmodule

// File: rtl/ppc_fwd_capture.sv
module ppc_fwd_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_i,
  input  logic          stb_i,
  input  logic          ack_i,
  input  logic [DW-1:0] bus_i,
  input  logic          pend_clr_i,
  output logic [DW-1:0] cap_o,
  output logic [1:0]    pend_o
);
  import ppc_pkg::*;
  logic stb_prev_q;
  logic fall;

  assign fall = stb_prev_q && !stb_i;

  always_ff @(posedge clk) begin
    if (rst) stb_prev_q <= 1'b1;
    else     stb_prev_q <= stb_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_o  <= '0;
      pend_o <= '0;
    end else if (fall && !dir_i) begin
      cap_o  <= bus_i;
      pend_o <= ack_i ? PEND_DATA : PEND_CMD;
    end else if (pend_clr_i) begin
      pend_o <= '0;
    end
  end

  AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
    (fall && !dir_i) |=> (pend_o != 2'b00)); // R3
  AST_REV_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    dir_i |=> $stable(cap_o)); // R9
endmodule

// File: rtl/ecp_port_capture.sv
module ecp_port_capture #(
  parameter int DW      = 8,
  parameter int AW      = 8,
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_sel_n_i,
  input  logic          host_stb_n_i,
  input  logic          host_ack_n_i,
  input  logic          host_init_n_i,
  input  logic [DW-1:0] pd_i,
  output logic [DW-1:0] pd_o,
  output logic          pd_oe_o,
  output logic          busy_o,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          reg_rvalid_o
);
  import ppc_pkg::*;
  localparam int LVL_PAD = DW - N_CTL;

  logic             dir_q, fen_q, last_cmd_q;
  logic [DIV_W-1:0] div_q;
  logic [DW-1:0]    data_q, cmd_q, bus_s1_q, bus_s2_q, cap;
  logic [1:0]       pend;
  logic             tick, pend_clr;
  logic [N_CTL-1:0] raw, lvl;
  logic             wr_data, wr_cmd, wr_ctrl, wr_div;

  assign raw[L_SEL]  = host_sel_n_i;
  assign raw[L_STB]  = host_stb_n_i;
  assign raw[L_ACK]  = host_ack_n_i;
  assign raw[L_INIT] = host_init_n_i;

  ppc_tick_div #(.DIV_W(DIV_W)) i_div (
    .clk(clk), .rst(rst), .div_i(div_q), .tick_o(tick));

  for (genvar g = 0; g < N_CTL; g++) begin : g_filt
    ppc_input_filter #(.RST_LVL(1'b1)) i_filt (
      .clk(clk), .rst(rst), .en_i(fen_q), .tick_i(tick),
      .async_i(raw[g]), .lvl_o(lvl[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_s1_q <= '0;
      bus_s2_q <= '0;
    end else begin
      bus_s1_q <= pd_i;
      bus_s2_q <= bus_s1_q;
    end
  end

  assign pend_clr = reg_rd_i && reg_addr_i == AW'(A_PEND);

  ppc_fwd_capture #(.DW(DW)) i_cap (
    .clk(clk), .rst(rst), .dir_i(dir_q), .stb_i(lvl[L_STB]),
    .ack_i(lvl[L_ACK]), .bus_i(bus_s2_q), .pend_clr_i(pend_clr),
    .cap_o(cap), .pend_o(pend));

  assign wr_data = reg_wr_i && reg_addr_i == AW'(A_DATA);
  assign wr_cmd  = reg_wr_i && reg_addr_i == AW'(A_CMD);
  assign wr_ctrl = reg_wr_i && reg_addr_i == AW'(A_CTRL);
  assign wr_div  = reg_wr_i && reg_addr_i == AW'(A_DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q      <= 1'b0;
      fen_q      <= 1'b1;
      div_q      <= DIV_W'(DIV_RST);
      data_q     <= '0;
      cmd_q      <= '0;
      last_cmd_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        dir_q <= reg_wdata_i[CTRL_DIR];
        fen_q <= reg_wdata_i[CTRL_FEN];
      end
      if (wr_div) div_q <= reg_wdata_i[DIV_W-1:0];
      if (wr_data) begin
        data_q     <= reg_wdata_i;
        last_cmd_q <= 1'b0;
      end
      if (wr_cmd) begin
        cmd_q      <= reg_wdata_i;
        last_cmd_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o  <= '0;
      reg_rvalid_o <= 1'b0;
    end else begin
      reg_rvalid_o <= reg_rd_i;
      if (reg_rd_i) begin
        unique case (reg_addr_i)
          AW'(A_DATA): reg_rdata_o <= dir_q ? data_q : cap;
          AW'(A_CMD):  reg_rdata_o <= dir_q ? cmd_q : cap;
          AW'(A_CTRL): begin
            reg_rdata_o           <= '0;
            reg_rdata_o[CTRL_DIR] <= dir_q;
            reg_rdata_o[CTRL_FEN] <= fen_q;
          end
          AW'(A_DIV):  reg_rdata_o <= DW'(div_q);
          AW'(A_PEND): reg_rdata_o <= {{(DW-2){1'b0}}, pend};
          AW'(A_LVL):  reg_rdata_o <= {{LVL_PAD{1'b0}}, lvl};
          default:     reg_rdata_o <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_o    <= '0;
      pd_oe_o <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      pd_oe_o <= dir_q;
      pd_o    <= last_cmd_q ? cmd_q : data_q;
      busy_o  <= dir_q && !last_cmd_q;
    end
  end

  AST_BUSY_CMD: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && dir_q) ##1 (!reg_wr_i && dir_q) |=> !busy_o); // R8
  AST_BUSY_DATA: assert property (@(posedge clk) disable iff (rst)
    (wr_data && dir_q) ##1 (!reg_wr_i && dir_q) |=> busy_o); // R8
  AST_OE_REVERSE: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && reg_wdata_i[CTRL_DIR]) ##1 !reg_wr_i |=> pd_oe_o); // R7
endmodule

// File: tb/test_ecp_port_capture.sv
module test_ecp_port_capture;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, stb_n = 1'b1, ack_n = 1'b1, init_n = 1'b1;
  logic [7:0] pd_i = '0;
  logic [7:0] pd_o;
  logic pd_oe, busy;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic rvalid;
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  ecp_port_capture i_ecp_port_capture (
    .clk(clk), .rst(rst), .host_sel_n_i(sel_n), .host_stb_n_i(stb_n),
    .host_ack_n_i(ack_n), .host_init_n_i(init_n), .pd_i(pd_i),
    .pd_o(pd_o), .pd_oe_o(pd_oe), .busy_o(busy), .reg_wr_i(wr),
    .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .reg_rvalid_o(rvalid));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) check("unexpected read", rdata, 8'h00);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); rd = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic host_byte(input logic [7:0] d, input logic ack, input int low_len);
    @(negedge clk); pd_i = d; ack_n = ack;
    cycles(24);
    stb_n = 1'b0;
    cycles(low_len);
    stb_n = 1'b1;
    cycles(24);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    cycles(4); rst = 1'b0; cycles(2);
    check("R1 pd_oe reset", {7'b0, pd_oe}, 8'h00);
    check("R1 busy reset", {7'b0, busy}, 8'h00);
    rd_reg(8'h60, 8'h00, "R1 data reg");
    rd_reg(8'h61, 8'h00, "R1 cmd reg");
    rd_reg(8'h64, 8'h00, "R1 pending");
    rd_reg(8'h62, 8'h40, "R1 control");
    rd_reg(8'h63, 8'h03, "R1 R6 period");

    host_byte(8'hA5, 1'b1, 40);
    rd_reg(8'h60, 8'hA5, "R2 capture data");
    rd_reg(8'h64, 8'h01, "R3 data flag");
    rd_reg(8'h64, 8'h00, "R3 clear on read");
    host_byte(8'h3C, 1'b0, 40);
    rd_reg(8'h61, 8'h3C, "R2 capture via 0x61");
    rd_reg(8'h64, 8'h02, "R3 command flag");

    wr_reg(8'h63, 8'h00);
    host_byte(8'h11, 1'b1, 2);
    rd_reg(8'h64, 8'h00, "R4 2-cycle pulse rejected");
    rd_reg(8'h60, 8'h3C, "R4 byte unchanged");
    host_byte(8'h22, 1'b1, 3);
    rd_reg(8'h64, 8'h01, "R4 3-cycle pulse accepted");
    rd_reg(8'h60, 8'h22, "R4 byte captured");

    wr_reg(8'h63, 8'h03);
    host_byte(8'h44, 1'b1, 6);
    rd_reg(8'h64, 8'h00, "R6 6-cycle pulse rejected");

    wr_reg(8'h62, 8'h00);
    host_byte(8'h55, 1'b0, 1);
    rd_reg(8'h64, 8'h02, "R5 1-cycle pulse unfiltered");
    rd_reg(8'h60, 8'h55, "R5 byte captured");

    @(negedge clk); sel_n = 1'b0; init_n = 1'b0; ack_n = 1'b1;
    cycles(6);
    rd_reg(8'h65, 8'h06, "R10 levels");
    sel_n = 1'b1; init_n = 1'b1;
    cycles(6);
    rd_reg(8'h65, 8'h0F, "R10 levels idle");

    wr_reg(8'h62, 8'h80);
    wr_reg(8'h60, 8'h9A);
    cycles(3);
    check("R7 oe", {7'b0, pd_oe}, 8'h01);
    check("R7 data drive", pd_o, 8'h9A);
    check("R8 busy data", {7'b0, busy}, 8'h01);
    wr_reg(8'h61, 8'h6B);
    cycles(3);
    check("R7 cmd drive", pd_o, 8'h6B);
    check("R8 busy cmd", {7'b0, busy}, 8'h00);
    rd_reg(8'h60, 8'h9A, "R7 data readback");
    rd_reg(8'h61, 8'h6B, "R7 cmd readback");

    host_byte(8'h77, 1'b0, 10);
    rd_reg(8'h64, 8'h00, "R9 no flags in reverse");
    wr_reg(8'h62, 8'h40);
    cycles(3);
    check("R8 busy forward", {7'b0, busy}, 8'h00);
    check("R7 oe off forward", {7'b0, pd_oe}, 8'h00);
    rd_reg(8'h60, 8'h55, "R9 capture unchanged");

    cycles(4);
    done = 1'b1;
    finish_run();
  end
endmodule